// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address presented to a memory array during a short burst. When the load strobe is low at a clock edge, it captures the full external address and drives it out as the first beat. Each later edge with the strobe high is an advance. On an advance the block forms the next beat address itself and ignores the external address. Only the two least-significant bits change. The upper bits stay at the loaded value for the whole burst. After four beats the low bits return to the start value and never carry upward.

A static order input picks how the low bits move. In linear order they count up by one modulo four. In interleaved order they are the start value XORed with the number of advances since the load. A clock enable freezes every register when it is low. The address output is registered, so a load or advance shows on the output after the edge that performs it.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, all state clears, and `addr_out` is 0 after that edge.
- R2: An edge with `clk_en`=1 and `ld_n`=0 makes `addr_out` equal to the `addr_in` sampled at that edge, and it resets the advance count to 0.
- R3: An edge with `clk_en`=1, `ld_n`=1 and `order`=0 (linear) sets the two low bits of `addr_out` to their previous value plus one, modulo 4. For example, start 1 gives 1,2,3,0.
- R4: An edge with `clk_en`=1, `ld_n`=1 and `order`=1 (interleaved) sets the two low bits to the loaded start bits XOR the advance count modulo 4. For example, start 1 gives 1,0,3,2.
- R5: The fifth beat after a load returns the low bits to the start value. It brings no carry into bit 2 or above, even from an all-ones address.
- R6: During advances, bits above bit 1 of `addr_out` keep their loaded value, and `addr_in` has no effect.
- R7: An edge with `clk_en`=0 changes nothing, whatever `ld_n` and `addr_in` are. The output and the advance count both resume unchanged afterwards.
- R8: A change of `order` does not alter `addr_out` by itself. It applies from the next advance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | 1 = edge acts, 0 = hold all state |
| ld_n | input | 1 | 0 = load a new burst, 1 = advance |
| order | input | 1 | 0 = linear, 1 = interleaved; static during use |
| addr_in | input | ADDR_W (20) | External start address |
| addr_out | output | ADDR_W (20) | Current beat address |

## Verification
Every result in this block is due one clock after the edge that causes it: loads, advances, holds and reset all land in the output register at that edge. The bench changes inputs 2 ns after a rising edge. It compares `addr_out` with a behavioural model 2 ns after the next rising edge, so every cycle yields one comparison. Cycles where `order` toggles, or where `clk_en` is low, are checked in the same slot. This shows that neither event moves the output before the next edge that acts.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } burst_order_e;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_STEP = 2'd2
    } seq_op_e;

    function automatic seq_op_e decode_op(input logic rst, input logic clk_en, input logic ld_n);
        if (rst)          return OP_LOAD;
        else if (!clk_en) return OP_HOLD;
        else if (!ld_n)   return OP_LOAD;
        else              return OP_STEP;
    endfunction

endpackage

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
    import burst_seq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  seq_op_e          op,
    output logic [CNT_W-1:0] beat,
    output logic [CNT_W-1:0] beat_nxt
);
    assign beat_nxt = beat + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            beat <= '0;
        end else begin
            unique case (op)
                OP_LOAD: beat <= '0;
                OP_STEP: beat <= beat_nxt;
                default: beat <= beat;
            endcase
        end
    end
endmodule

// File: rtl/burst_start_reg.sv
module burst_start_reg
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_op_e           op,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] start_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            start_addr <= '0;
        end else if (op == OP_LOAD) begin
            start_addr <= addr_in;
        end
    end
endmodule

// File: rtl/burst_low_gen.sv
module burst_low_gen
    import burst_seq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  seq_op_e          op,
    input  burst_order_e     order,
    input  logic [CNT_W-1:0] load_low,
    input  logic [CNT_W-1:0] start_low,
    input  logic [CNT_W-1:0] beat_nxt,
    output logic [CNT_W-1:0] cur_low
);
    logic [CNT_W-1:0] lin_nxt;
    logic [CNT_W-1:0] ilv_nxt;
    logic [CNT_W-1:0] step_nxt;

    assign lin_nxt = cur_low + CNT_W'(1);

    for (genvar b = 0; b < CNT_W; b++) begin : g_ilv_bit
        assign ilv_nxt[b] = start_low[b] ^ beat_nxt[b];
    end

    assign step_nxt = (order == ORDER_INTERLEAVE) ? ilv_nxt : lin_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_low <= '0;
        end else begin
            unique case (op)
                OP_LOAD: cur_low <= load_low;
                OP_STEP: cur_low <= step_nxt;
                default: cur_low <= cur_low;
            endcase
        end
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              ld_n,
    input  logic              order,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int HI_W = ADDR_W - CNT_W;

    seq_op_e           op;
    burst_order_e      order_sel;
    logic [CNT_W-1:0]  beat;
    logic [CNT_W-1:0]  beat_nxt;
    logic [ADDR_W-1:0] start_addr;
    logic [CNT_W-1:0]  cur_low;

    assign op        = decode_op(1'b0, clk_en, ld_n);
    assign order_sel = burst_order_e'(order);

    burst_beat_counter #(.CNT_W(CNT_W)) u_beat (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .beat     (beat),
        .beat_nxt (beat_nxt)
    );

    burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .addr_in    (addr_in),
        .start_addr (start_addr)
    );

    burst_low_gen #(.CNT_W(CNT_W)) u_low (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .order     (order_sel),
        .load_low  (addr_in[CNT_W-1:0]),
        .start_low (start_addr[CNT_W-1:0]),
        .beat_nxt  (beat_nxt),
        .cur_low   (cur_low)
    );

    assign addr_out = {start_addr[ADDR_W-1:CNT_W], cur_low};

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = start_addr[ADDR_W-1:CNT_W];
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              clk_en,
    input logic              ld_n,
    input logic              order,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic [CNT_W-1:0]  beat,
    input logic [ADDR_W-1:0] start_addr
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> addr_out == '0);

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !ld_n) |=> addr_out == $past(addr_in));

    // R3
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_en && ld_n && !order) |=>
        addr_out[CNT_W-1:0] == $past(addr_out[CNT_W-1:0]) + CNT_W'(1));

    // R4
    interleave_step_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_en && ld_n && order) |=>
        addr_out[CNT_W-1:0] == (start_addr[CNT_W-1:0] ^ beat));

    // R6
    upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_en && ld_n) |=>
        addr_out[ADDR_W-1:CNT_W] == $past(addr_out[ADDR_W-1:CNT_W]));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> $stable(addr_out) && $stable(beat));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clk_en     (clk_en),
    .ld_n       (ld_n),
    .order      (order),
    .addr_in    (addr_in),
    .addr_out   (addr_out),
    .beat       (beat),
    .start_addr (start_addr)
);

// File: tb/burst_addr_seq_tb.sv
`timescale 1ns/1ps
module burst_addr_seq_tb;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clk_en = 1'b0;
    logic          ld_n = 1'b1;
    logic          order = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural reference state
    int m_base = 0;
    int m_beat = 0;
    int m_low  = 0;

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .CNT_W(2)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .clk_en   (clk_en),
        .ld_n     (ld_n),
        .order    (order),
        .addr_in  (addr_in),
        .addr_out (addr_out)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_base = 0; m_beat = 0; m_low = 0;
        end else if (clk_en) begin
            if (!ld_n) begin
                m_base = int'(addr_in); m_beat = 0; m_low = int'(addr_in) % 4;
            end else begin
                m_beat = (m_beat + 1) % 4;
                if (order) m_low = (m_base % 4) ^ m_beat;
                else       m_low = (m_low + 1) % 4;
            end
        end
    end

    function automatic int expected();
        return (m_base - (m_base % 4)) + m_low;
    endfunction

    task automatic cyc(input bit r, input bit ce, input bit ld, input bit md,
                       input int a, input string req);
        rst = r; clk_en = ce; ld_n = ld; order = md; addr_in = AW'(a);
        @(posedge clk);
        #2;
        n_cmp++;
        if (int'(addr_out) != expected()) begin
            n_bad++;
            $display("FAIL %s: addr_out=%05h expected=%05h", req, addr_out, expected());
        end
    endtask

    initial begin
        #2;
        cyc(1, 0, 1, 0, 'h3, "R1");
        cyc(1, 1, 0, 0, 'h7, "R1");
        // linear from start 1, foreign addr_in on advances
        cyc(0, 1, 0, 0, 'h12345, "R2");
        for (int i = 0; i < 3; i++) cyc(0, 1, 1, 0, 'hFFFF0 + i, "R3");
        cyc(0, 1, 1, 0, 'h00000, "R6");
        cyc(0, 1, 1, 0, 'h0AAAA, "R5");
        // interleaved from start 3
        cyc(0, 1, 0, 1, 'hABCD3, "R2");
        for (int i = 0; i < 3; i++) cyc(0, 1, 1, 1, 'h11110, "R4");
        cyc(0, 1, 1, 1, 'h22222, "R5");
        cyc(0, 1, 1, 1, 'h33333, "R4");
        // interleaved from start 1
        cyc(0, 1, 0, 1, 'h40001, "R2");
        for (int i = 0; i < 4; i++) cyc(0, 1, 1, 1, 'h0, "R4");
        // all-ones address: no carry
        cyc(0, 1, 0, 0, 'hFFFFF, "R2");
        for (int i = 0; i < 4; i++) cyc(0, 1, 1, 0, 'h0, "R5");
        cyc(0, 1, 0, 1, 'hFFFFE, "R2");
        for (int i = 0; i < 4; i++) cyc(0, 1, 1, 1, 'h0, "R5");
        // clock enable low mid-burst, with a load attempt
        cyc(0, 1, 0, 0, 'h00002, "R2");
        cyc(0, 1, 1, 0, 'h0, "R3");
        cyc(0, 0, 0, 0, 'h77777, "R7");
        cyc(0, 0, 1, 1, 'h12121, "R7");
        cyc(0, 1, 1, 0, 'h0, "R7");
        cyc(0, 1, 1, 0, 'h0, "R7");
        cyc(0, 1, 1, 0, 'h0, "R5");
        // order change mid-burst
        cyc(0, 1, 0, 0, 'h55551, "R2");
        cyc(0, 1, 1, 0, 'h0, "R3");
        cyc(0, 0, 1, 1, 'h0, "R8");
        cyc(0, 1, 1, 1, 'h0, "R8");
        cyc(0, 1, 1, 0, 'h0, "R8");
        cyc(0, 1, 1, 0, 'h0, "R8");
        // reset mid-burst
        cyc(1, 1, 1, 0, 'h0, "R1");
        cyc(0, 1, 1, 0, 'h0, "R3");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule